// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state and the tag of every line in a direct-mapped private cache and runs an invalidation protocol with four states: Modified, Exclusive (sole copy, clean), Shared and Invalid. It serves one processor request at a time. Read hits and writes to lines already held with ownership finish locally. All other requests become a bus transaction: a read (BusRd) for a read miss, or a read-for-ownership (BusRdX) for a write to a Shared or absent line.

While its own transactions are in flight, the block also watches the transactions of the other caches on the bus. It drives a wired-OR "shared" line when it holds a copy the reader asks for. It signals a flush when it gives up dirty data, and a cache-to-cache transfer when it supplies a clean Exclusive line. When its own read miss completes, it samples that same shared line to choose Exclusive or Shared. A later write to an Exclusive line then reaches Modified without a bus transaction.

An address is split into a line index (low `IDX_W` bits) and a tag (the remaining high bits). The data array, memory timing and bus arbitration are outside the block.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_done`, `bus_out_valid`, `shared_out`, `flush_out` and `c2c_out` are all low.
- R2: A processor read whose line is valid with a matching tag raises `cpu_done` in the cycle after the request, issues no bus request and leaves the line state unchanged.
- R3: A read miss raises `bus_out_valid` in the cycle after the request, with `bus_out_rdx` = 0 (BusRd) and the request address. Command and address stay stable until the cycle in which `bus_grant` is high; that cycle is the address phase.
- R4: The shared line is sampled in the cycle right after the address phase. The missed line becomes Shared if the shared line is high in that cycle and Exclusive otherwise, and `cpu_done` rises one cycle later.
- R5: A processor write to an Exclusive line makes it Modified, raises `cpu_done` the next cycle and issues no bus request.
- R6: A processor write to a Shared line, or one that misses, issues `bus_out_rdx` = 1 (BusRdX) with the same timing as R3/R4. The line then becomes Modified, whatever the shared line does.
- R7: A processor write to a Modified line completes in the next cycle with no bus request.
- R8: A snooped BusRd (`snp_rdx` = 0) that hits a valid line raises `shared_out` for exactly the cycle after the snoop address phase.
- R9: A snooped BusRd that hits an Exclusive line raises `c2c_out` in that same cycle and leaves the line Shared.
- R10: A snooped BusRd that hits a Modified line raises `flush_out` in that same cycle and leaves the line Shared.
- R11: A snooped BusRdX (`snp_rdx` = 1) that hits a valid line makes it Invalid. It raises `flush_out` only if the line was Modified and never raises `shared_out` or `c2c_out`.
- R12: A snoop whose tag does not match, or whose line is Invalid, produces no response and changes no state.
- R13: A processor request made while a bus transaction of the block is still pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | One-cycle processor request pulse |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address of the request |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_out_valid | output | 1 | Block requests a bus transaction |
| bus_out_rdx | output | 1 | 0 = BusRd, 1 = BusRdX |
| bus_out_addr | output | ADDR_W | Address of the requested transaction |
| bus_grant | input | 1 | High in the address phase of the block's transaction |
| snp_valid | input | 1 | Address phase of another cache's transaction |
| snp_rdx | input | 1 | 0 = BusRd, 1 = BusRdX for the snooped transaction |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| shared_in | input | 1 | Wired-OR shared line from the other caches |
| shared_out | output | 1 | This block's contribution to the shared line |
| flush_out | output | 1 | Dirty data supplied for a snooped transaction |
| c2c_out | output | 1 | Clean data supplied cache to cache |

## Verification
The bench builds the controller with `ADDR_W` = 6 and `IDX_W` = 2: four lines and sixteen tags per line. With so few lines, random traffic often replaces lines and often sends snoops to an index whose tag differs. The same small space lets directed sequences walk every state through each processor and snoop event. Snoops and ignored processor pulses are also injected while the block waits for its grant. This brings pending upgrades that lose their copy, and requests dropped while busy, within reach.

// File: rtl/mesi_ctrl_pkg.sv
package mesi_ctrl_pkg;

    // Line state encoding: I=0, S=1, E=2, M=3
    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_t;

    // Controller phase
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_BUSREQ = 2'd1,
        PH_SAMPLE = 2'd2
    } ctrl_ph_t;

endpackage

// File: rtl/mesi_tag_probe.sv
module mesi_tag_probe
    import mesi_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3,
    localparam int LINES = 1 << IDX_W,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic [LINES-1:0][1:0]       st_vec,
    input  logic [LINES-1:0][TAG_W-1:0] tag_vec,
    input  logic [ADDR_W-1:0]           addr,
    output logic [IDX_W-1:0]            idx,
    output line_st_t                    hit_st
);
    logic [TAG_W-1:0] tag;

    assign idx    = addr[IDX_W-1:0];
    assign tag    = addr[ADDR_W-1:IDX_W];
    assign hit_st = (tag_vec[idx] == tag) ? line_st_t'(st_vec[idx]) : LS_I;
endmodule

// File: rtl/mesi_cpu_rule.sv
module mesi_cpu_rule
    import mesi_ctrl_pkg::*;
(
    input  line_st_t cur,
    input  logic     wr,
    output logic     local_ok,
    output line_st_t nxt
);
    always_comb begin
        if (wr) begin
            // ownership already held: silent move to Modified
            local_ok = (cur == LS_E) || (cur == LS_M);
            nxt      = LS_M;
        end else begin
            local_ok = (cur != LS_I);
            nxt      = cur;
        end
    end
endmodule

// File: rtl/mesi_snoop_rule.sv
module mesi_snoop_rule
    import mesi_ctrl_pkg::*;
(
    input  logic     valid,
    input  logic     rdx,
    input  line_st_t cur,
    output logic     touch,
    output line_st_t nxt,
    output logic     shared,
    output logic     flush,
    output logic     c2c
);
    always_comb begin
        touch  = valid && (cur != LS_I);
        shared = touch && !rdx;
        flush  = touch && (cur == LS_M);
        c2c    = touch && !rdx && (cur == LS_E);
        nxt    = rdx ? LS_I : LS_S;
    end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_done,
    output logic              bus_out_valid,
    output logic              bus_out_rdx,
    output logic [ADDR_W-1:0] bus_out_addr,
    input  logic              bus_grant,
    input  logic              snp_valid,
    input  logic              snp_rdx,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              shared_in,
    output logic              shared_out,
    output logic              flush_out,
    output logic              c2c_out
);
    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        ctrl_ph_t                    ph;
        logic [LINES-1:0][1:0]       st;
        logic [LINES-1:0][TAG_W-1:0] tg;
        logic [ADDR_W-1:0]           raddr;
        logic                        rwr;
        logic                        done;
        logic                        shr;
        logic                        fl;
        logic                        xf;
    } regs_t;

    regs_t d, q;

    // processor-side lookup
    logic [IDX_W-1:0] c_idx;
    line_st_t         c_st, c_nxt;
    logic             c_ok;

    mesi_tag_probe #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cpu_probe (
        .st_vec(q.st), .tag_vec(q.tg), .addr(cpu_req_addr),
        .idx(c_idx), .hit_st(c_st)
    );

    mesi_cpu_rule u_cpu_rule (
        .cur(c_st), .wr(cpu_req_write), .local_ok(c_ok), .nxt(c_nxt)
    );

    // snoop-side lookup
    logic [IDX_W-1:0] s_idx;
    line_st_t         s_st, s_nxt;
    logic             s_touch, s_shared, s_flush, s_c2c;

    mesi_tag_probe #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snp_probe (
        .st_vec(q.st), .tag_vec(q.tg), .addr(snp_addr),
        .idx(s_idx), .hit_st(s_st)
    );

    mesi_snoop_rule u_snp_rule (
        .valid(snp_valid), .rdx(snp_rdx), .cur(s_st),
        .touch(s_touch), .nxt(s_nxt),
        .shared(s_shared), .flush(s_flush), .c2c(s_c2c)
    );

    // pending request fields
    logic [IDX_W-1:0] r_idx;
    logic [TAG_W-1:0] r_tag;
    assign r_idx = q.raddr[IDX_W-1:0];
    assign r_tag = q.raddr[ADDR_W-1:IDX_W];

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (cpu_req_valid) begin
                    if (c_ok) begin
                        d.done       = 1'b1;
                        d.st[c_idx]  = c_nxt;
                    end else begin
                        d.ph    = PH_BUSREQ;
                        d.raddr = cpu_req_addr;
                        d.rwr   = cpu_req_write;
                    end
                end
            end
            PH_BUSREQ: begin
                if (bus_grant) d.ph = PH_SAMPLE;
            end
            PH_SAMPLE: begin
                d.st[r_idx] = q.rwr ? LS_M : (shared_in ? LS_S : LS_E);
                d.tg[r_idx] = r_tag;
                d.done      = 1'b1;
                d.ph        = PH_IDLE;
            end
            default: d.ph = PH_IDLE;
        endcase
        // bus order wins over a same-cycle processor update
        if (s_touch) d.st[s_idx] = s_nxt;
        d.shr = s_shared;
        d.fl  = s_flush;
        d.xf  = s_c2c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cpu_done      = q.done;
    assign bus_out_valid = (q.ph == PH_BUSREQ);
    assign bus_out_rdx   = q.rwr;
    assign bus_out_addr  = q.raddr;
    assign shared_out    = q.shr;
    assign flush_out     = q.fl;
    assign c2c_out       = q.xf;

    // R3
    busreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_out_valid && !bus_grant |=> bus_out_valid && $stable(bus_out_addr) && $stable(bus_out_rdx));

    // R4
    grant_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_out_valid && bus_grant |=> !bus_out_valid ##1 cpu_done);

    // R8
    shared_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shared_out |-> $past(snp_valid && !snp_rdx));

    // R9
    c2c_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c2c_out |-> $past(snp_valid && !snp_rdx) && !flush_out && shared_out);

    // R10
    flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_out |-> $past(snp_valid));

    // R2
    done_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !bus_out_valid);
endmodule

// File: tb/mesi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_test;
    localparam int AW = 6;
    localparam int IW = 2;
    localparam int LN = 1 << IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          cpu_req_valid = 0, cpu_req_write = 0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic          bus_grant = 0, snp_valid = 0, snp_rdx = 0, shared_in = 0;
    logic [AW-1:0] snp_addr = '0;
    logic          cpu_done, bus_out_valid, bus_out_rdx, shared_out, flush_out, c2c_out;
    logic [AW-1:0] bus_out_addr;

    mesi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_done(cpu_done),
        .bus_out_valid(bus_out_valid), .bus_out_rdx(bus_out_rdx), .bus_out_addr(bus_out_addr),
        .bus_grant(bus_grant),
        .snp_valid(snp_valid), .snp_rdx(snp_rdx), .snp_addr(snp_addr),
        .shared_in(shared_in), .shared_out(shared_out), .flush_out(flush_out), .c2c_out(c2c_out)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // behavioural reference: 0=I 1=S 2=E 3=M
    int mst[LN];
    int mtag[LN];
    int mph;
    int maddr;
    bit mwr, e_done, e_shr, e_fl, e_xf;

    always @(posedge clk) begin : model
        int si, ci;
        bit s_hit, c_hit;
        if (!rst_n) begin
            for (int i = 0; i < LN; i++) begin mst[i] = 0; mtag[i] = 0; end
            mph = 0; maddr = 0; mwr = 0;
            e_done = 0; e_shr = 0; e_fl = 0; e_xf = 0;
        end else begin
            si    = int'(snp_addr) % LN;
            s_hit = snp_valid && mst[si] != 0 && mtag[si] == int'(snp_addr) / LN;
            e_shr = s_hit && !snp_rdx;
            e_fl  = s_hit && mst[si] == 3;
            e_xf  = s_hit && !snp_rdx && mst[si] == 2;
            e_done = 0;
            if (mph == 0) begin
                if (cpu_req_valid) begin
                    ci    = int'(cpu_req_addr) % LN;
                    c_hit = mst[ci] != 0 && mtag[ci] == int'(cpu_req_addr) / LN;
                    if (c_hit && !cpu_req_write) e_done = 1;
                    else if (c_hit && mst[ci] >= 2) begin mst[ci] = 3; e_done = 1; end
                    else begin mph = 1; maddr = int'(cpu_req_addr); mwr = cpu_req_write; end
                end
            end else if (mph == 1) begin
                if (bus_grant) mph = 2;
            end else begin
                ci = maddr % LN;
                mst[ci]  = mwr ? 3 : (shared_in ? 1 : 2);
                mtag[ci] = maddr / LN;
                e_done = 1;
                mph = 0;
            end
            if (s_hit) mst[si] = snp_rdx ? 0 : 1;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("cpu_done", 32'(cpu_done), 32'(e_done));
            chk("bus_out_valid", 32'(bus_out_valid), 32'(mph == 1));
            if (mph == 1) begin
                chk("bus_out_rdx", 32'(bus_out_rdx), 32'(mwr));
                chk("bus_out_addr", 32'(bus_out_addr), 32'(maddr));
            end
            chk("shared_out", 32'(shared_out), 32'(e_shr));
            chk("flush_out", 32'(flush_out), 32'(e_fl));
            chk("c2c_out", 32'(c2c_out), 32'(e_xf));
        end
    end

    task automatic cpu_op(bit wr, int addr, bit sh, int gdly, bit noisy);
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = AW'(addr);
        @(negedge clk);
        cpu_req_valid = 0;
        if (mph == 1) begin
            for (int k = 0; k < gdly; k++) begin
                if (noisy) begin
                    snp_valid = 1'($urandom % 2);
                    snp_rdx = 1'($urandom % 2);
                    snp_addr = AW'($urandom);
                    cpu_req_valid = 1'($urandom % 2);
                    cpu_req_write = 1'($urandom % 2);
                    cpu_req_addr = AW'($urandom);
                end
                @(negedge clk);
            end
            snp_valid = 0; cpu_req_valid = 0; bus_grant = 1;
            @(negedge clk);
            bus_grant = 0; shared_in = sh;
            @(negedge clk);
            shared_in = 0;
            @(negedge clk);
        end
    endtask

    task automatic snoop(bit rdx, int addr);
        @(negedge clk);
        snp_valid = 1; snp_rdx = rdx; snp_addr = AW'(addr);
        @(negedge clk);
        snp_valid = 0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        repeat (2) @(negedge clk);
        for (int i = 0; i < LN; i++) snoop(0, i);
        cur_req = "R3";  cpu_op(0, 6'h05, 0, 2, 0);   // miss -> E
        cur_req = "R5";  cpu_op(1, 6'h05, 0, 0, 0);   // E -> M silently
        cur_req = "R10"; snoop(0, 6'h05);             // M -> S with flush
        cur_req = "R11"; snoop(1, 6'h05);             // S -> I
        cur_req = "R12"; snoop(0, 6'h05);             // invalid: ignored
        cur_req = "R4";  cpu_op(0, 6'h06, 1, 1, 0);   // miss with shared -> S
        cur_req = "R2";  cpu_op(0, 6'h06, 0, 0, 0);
        cur_req = "R8";  snoop(0, 6'h06);
        cur_req = "R6";  cpu_op(1, 6'h06, 1, 0, 0);   // upgrade S -> M
        cur_req = "R7";  cpu_op(1, 6'h06, 0, 0, 0);
        cur_req = "R12"; snoop(0, 6'h16);             // tag mismatch
        cur_req = "R11"; snoop(1, 6'h06);             // M -> I with flush
        cur_req = "R9";  cpu_op(0, 6'h07, 0, 0, 0);
        snoop(0, 6'h07);                              // E -> S with c2c
        cur_req = "R2";  cpu_op(0, 6'h07, 0, 0, 0);
        cur_req = "R6";  cpu_op(1, 6'h08, 1, 3, 0);   // write miss
        cur_req = "R13"; cpu_op(0, 6'h09, 0, 4, 1);
        cur_req = "R4";
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 3 == 0) snoop(1'($urandom % 2), int'($urandom % 64));
            else cpu_op(1'($urandom % 2), int'($urandom % 64), 1'($urandom % 2),
                        int'($urandom % 4), 1'($urandom % 2));
        end
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule